// File: doc/BRIEF.md
# Interprocessor Message Mailbox

This block lets an application processor and an I/O coprocessor exchange short messages through two independent 16-entry FIFOs. One FIFO (A2I) carries traffic from the application processor to the coprocessor. The other (I2A) carries traffic the other way. Each message is a 64-bit first word and a 32-bit second word. Both processors reach the block through one shared 64-bit register port.

A sender first writes the first word to a staging register. It then writes the second word, and that write commits the whole message. A receiver may read the head's first word without side effects. Reading the head's second word pops the entry. That read also returns live pointer and occupancy fields above the 32-bit payload.

Four event bits track the empty and not-empty state of both FIFOs. Each event bit is sticky until software acknowledges it. Each event can be masked by an enable bit. The events drive two level-sensitive interrupt lines.

Top module: `ipc_mbox`

## Requirements
- R1: After reset both FIFOs are empty. Both interrupt outputs are low and the interrupt enable register (0x48) reads 0.
- R2: A write to the first send word (A2I 0x60, I2A 0x90) loads a staging register. A write to the second send word (0x68, 0x98) then commits {staged word, wrData[31:0]} to that FIFO; wrData[63:32] of that write is ignored. Messages leave in the order they were committed.
- R3: The direction status register (A2I 0x50, I2A 0x80) reads bit 16 = full, meaning 16 entries are held. It reads bit 17 = empty. All other bits read 0, and writes to it have no effect.
- R4: A commit while the FIFO is full is dropped and changes no stored entry, pointer or count.
- R5: Reading the first receive word (A2I 0x70, I2A 0xA0) returns the head's first word and does not pop. Reading the second receive word (0x78, 0xA8) returns the head's second word in bits 31:0 and pops the entry.
- R6: A receive read while the FIFO is empty returns 0 in the payload bits and leaves the pointers unchanged.
- R7: Each second-receive-word read returns the state from before its own pop, with all other bits 0:
  - bits 43:40: the write index;
  - bits 47:44: the read index;
  - bits 51:48: the free-slot count, saturated at 15;
  - bits 56:52: the occupancy, 0 to 16.
- R8: The event bits are: bit 0 A2I empty, bit 1 A2I not empty, bit 2 I2A empty, bit 3 I2A not empty. An event latches while its condition holds and stays latched after the condition ends. Reading 0x4C returns the latched events.
- R9: Writing 1 to a bit of 0x4C clears that latched event. If the condition is still true, the event stays asserted with no gap.
- R10: irqEmpty is the OR of latched events 0 and 2, each ANDed with its enable bit in 0x48 (bits 3:0, same layout). irqNotEmpty is the same for events 1 and 3.
- R11: Read data appears on rdData with rdValid high in the cycle after rdEn. Unmapped addresses read 0.
- R12: Traffic on one direction leaves the other direction's status and contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 8 | Register byte address |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 64 | Write data |
| rdEn | input | 1 | Register read strobe |
| rdValid | output | 1 | Read data valid, one cycle after rdEn |
| rdData | output | 64 | Registered read data |
| irqEmpty | output | 1 | Level interrupt from the enabled empty events |
| irqNotEmpty | output | 1 | Level interrupt from the enabled not-empty events |

## Verification
A wrong pointer or occupancy value is visible within one read: the status fields of every second-receive-word read expose both indices and the count, and a drifted read index also returns the wrong payload. A lost or spurious event latch shows on an interrupt line one cycle after the write that unmasks or acknowledges it. Because the latches are sticky, a missed set stays visible until the next acknowledge instead of passing in a single cycle. Filling a FIFO to 16 entries and wrapping both indices exposes off-by-one errors in the full flag and in the free-slot saturation.

// File: rtl/ipc_mbox_pkg.sv
package ipc_mbox_pkg;
  localparam int REG_W    = 64;
  localparam int ADDR_W   = 8;
  localparam int WORD1_W  = 32;
  localparam int MSG_W    = REG_W + WORD1_W;
  localparam int NUM_DIR  = 2;
  localparam int IRQ_N    = 2 * NUM_DIR;

  localparam int BIT_FULL   = 16;
  localparam int BIT_EMPTY  = 17;
  localparam int POS_WIDX   = 40;
  localparam int POS_RIDX   = 44;
  localparam int POS_FREE   = 48;
  localparam int POS_OCC    = 52;
  localparam int IDX_FLD_W  = 4;
  localparam int OCC_FLD_W  = 5;

  localparam logic [ADDR_W-1:0] OFS_IRQ_EN  = 8'h48;
  localparam logic [ADDR_W-1:0] OFS_IRQ_ACK = 8'h4C;

  typedef enum logic [2:0] {
    RK_NONE, RK_STATUS, RK_HEAD0, RK_HEAD1, RK_IRQEN, RK_IRQLAT
  } rdKind_e;

  typedef struct packed {
    logic [NUM_DIR-1:0] stage;
    logic [NUM_DIR-1:0] push;
    logic [NUM_DIR-1:0] pop;
    logic               rdDir;
    rdKind_e            rdKind;
  } mboxStrobe_t;

  function automatic logic [ADDR_W-1:0] statusOfs(input int d);
    return (d == 0) ? 8'h50 : 8'h80;
  endfunction

  function automatic logic [ADDR_W-1:0] sendOfs(input int d);
    return (d == 0) ? 8'h60 : 8'h90;
  endfunction

  function automatic logic [ADDR_W-1:0] recvOfs(input int d);
    return (d == 0) ? 8'h70 : 8'hA0;
  endfunction
endpackage

// File: rtl/ipc_mbox_fifo.sv
module ipc_mbox_fifo #(
  parameter int DEPTH = 16,
  parameter int MSG_W = 96,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic             pop,
  input  logic [MSG_W-1:0] wrMsg,
  output logic [MSG_W-1:0] headMsg,
  output logic [PTR_W-1:0] wrIdx,
  output logic [PTR_W-1:0] rdIdx,
  output logic [CNT_W-1:0] occ,
  output logic             full,
  output logic             empty
);
  logic [MSG_W-1:0] mem [DEPTH];

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wrIdx] <= wrMsg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrIdx <= '0;
      rdIdx <= '0;
      occ   <= '0;
    end else begin
      if (push) wrIdx <= bump(wrIdx);
      if (pop)  rdIdx <= bump(rdIdx);
      if (push && !pop)      occ <= occ + 1'b1;
      else if (pop && !push) occ <= occ - 1'b1;
    end
  end

  assign headMsg = mem[rdIdx];
  assign full    = (occ == CNT_W'(DEPTH));
  assign empty   = (occ == '0);

  // R4
  no_push_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    push |-> !full);
  // R6
  no_pop_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    pop |-> !empty);
  // R3
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    occ <= CNT_W'(DEPTH));
  // R2
  occ_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (push && !pop) |=> (occ == $past(occ) + 1'b1));
endmodule

// File: rtl/ipc_mbox_datapath.sv
module ipc_mbox_datapath
  import ipc_mbox_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  mboxStrobe_t        strobe,
  input  logic [REG_W-1:0]   wrData,
  output logic [NUM_DIR-1:0] dirFull,
  output logic [NUM_DIR-1:0] dirEmpty,
  output logic [REG_W-1:0]   dpRdData
);
  logic [REG_W-1:0] stageQ  [NUM_DIR];
  logic [MSG_W-1:0] headMsg [NUM_DIR];
  logic [PTR_W-1:0] wrIdx   [NUM_DIR];
  logic [PTR_W-1:0] rdIdx   [NUM_DIR];
  logic [CNT_W-1:0] occ     [NUM_DIR];

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    always_ff @(posedge clk) begin
      if (!rstN)              stageQ[d] <= '0;
      else if (strobe.stage[d]) stageQ[d] <= wrData;
    end

    ipc_mbox_fifo #(.DEPTH(DEPTH), .MSG_W(MSG_W)) u_fifo (
      .clk     (clk),
      .rstN    (rstN),
      .push    (strobe.push[d]),
      .pop     (strobe.pop[d]),
      .wrMsg   ({stageQ[d], wrData[WORD1_W-1:0]}),
      .headMsg (headMsg[d]),
      .wrIdx   (wrIdx[d]),
      .rdIdx   (rdIdx[d]),
      .occ     (occ[d]),
      .full    (dirFull[d]),
      .empty   (dirEmpty[d])
    );
  end

  logic [CNT_W-1:0] freeSlots;
  logic             selDir;

  always_comb begin
    selDir    = strobe.rdDir;
    freeSlots = CNT_W'(DEPTH) - occ[selDir];
    dpRdData  = '0;
    case (strobe.rdKind)
      RK_STATUS: begin
        dpRdData[BIT_FULL]  = dirFull[selDir];
        dpRdData[BIT_EMPTY] = dirEmpty[selDir];
      end
      RK_HEAD0: begin
        if (!dirEmpty[selDir]) dpRdData = headMsg[selDir][MSG_W-1:WORD1_W];
      end
      RK_HEAD1: begin
        dpRdData[POS_WIDX +: IDX_FLD_W] = IDX_FLD_W'(wrIdx[selDir]);
        dpRdData[POS_RIDX +: IDX_FLD_W] = IDX_FLD_W'(rdIdx[selDir]);
        dpRdData[POS_FREE +: IDX_FLD_W] =
          (freeSlots > CNT_W'(15)) ? 4'hF : IDX_FLD_W'(freeSlots);
        dpRdData[POS_OCC +: OCC_FLD_W]  = OCC_FLD_W'(occ[selDir]);
        if (!dirEmpty[selDir])
          dpRdData[WORD1_W-1:0] = headMsg[selDir][WORD1_W-1:0];
      end
      default: ;
    endcase
  end

  // R12
  stage_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stage == '0) |=> (stageQ[0] == $past(stageQ[0]) && stageQ[1] == $past(stageQ[1])));
endmodule

// File: rtl/ipc_mbox_ctrl.sv
module ipc_mbox_ctrl
  import ipc_mbox_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wrEn,
  input  logic [IRQ_N-1:0]   wrLow,
  input  logic               rdEn,
  input  logic [NUM_DIR-1:0] dirFull,
  input  logic [NUM_DIR-1:0] dirEmpty,
  input  logic [REG_W-1:0]   dpRdData,
  output mboxStrobe_t        strobe,
  output logic               rdValid,
  output logic [REG_W-1:0]   rdData,
  output logic               irqEmpty,
  output logic               irqNotEmpty
);
  localparam logic [IRQ_N-1:0] EMPTY_MASK    = 4'b0101;
  localparam logic [IRQ_N-1:0] NOTEMPTY_MASK = 4'b1010;

  logic [IRQ_N-1:0] enQ, latQ, ackMask, cond;
  logic             enWr;

  always_comb begin
    strobe = '0;
    for (int d = 0; d < NUM_DIR; d++) begin
      strobe.stage[d] = wrEn && (addr == sendOfs(d));
      strobe.push[d]  = wrEn && (addr == sendOfs(d) + 8'h08) && !dirFull[d];
      strobe.pop[d]   = rdEn && (addr == recvOfs(d) + 8'h08) && !dirEmpty[d];
    end
    strobe.rdKind = RK_NONE;
    strobe.rdDir  = 1'b0;
    if (rdEn) begin
      if (addr == OFS_IRQ_EN)  strobe.rdKind = RK_IRQEN;
      if (addr == OFS_IRQ_ACK) strobe.rdKind = RK_IRQLAT;
      for (int d = 0; d < NUM_DIR; d++) begin
        if (addr == statusOfs(d)) begin
          strobe.rdKind = RK_STATUS; strobe.rdDir = 1'(d);
        end
        if (addr == recvOfs(d)) begin
          strobe.rdKind = RK_HEAD0;  strobe.rdDir = 1'(d);
        end
        if (addr == recvOfs(d) + 8'h08) begin
          strobe.rdKind = RK_HEAD1;  strobe.rdDir = 1'(d);
        end
      end
    end
  end

  assign enWr    = wrEn && (addr == OFS_IRQ_EN);
  assign ackMask = (wrEn && (addr == OFS_IRQ_ACK)) ? wrLow : '0;
  assign cond    = {~dirEmpty[1], dirEmpty[1], ~dirEmpty[0], dirEmpty[0]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ  <= '0;
      latQ <= '0;
    end else begin
      if (enWr) enQ <= wrLow;
      latQ <= (latQ & ~ackMask) | cond;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= rdEn;
      case (strobe.rdKind)
        RK_IRQEN:  rdData <= REG_W'(enQ);
        RK_IRQLAT: rdData <= REG_W'(latQ);
        default:   rdData <= dpRdData;
      endcase
    end
  end

  assign irqEmpty    = |(latQ & enQ & EMPTY_MASK);
  assign irqNotEmpty = |(latQ & enQ & NOTEMPTY_MASK);

  // R8
  sticky_event_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(latQ) & ~$past(ackMask) & ~latQ) == '0));
  // R9
  ack_reassert_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((ackMask & cond) != '0) |=> ((latQ & $past(ackMask & cond)) == $past(ackMask & cond)));
  // R10
  empty_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (((enQ & cond & EMPTY_MASK) != '0) && !enWr) |=> irqEmpty);
  // R10
  notempty_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (((enQ & cond & NOTEMPTY_MASK) != '0) && !enWr) |=> irqNotEmpty);
endmodule

// File: rtl/ipc_mbox.sv
module ipc_mbox
  import ipc_mbox_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [REG_W-1:0]  wrData,
  input  logic              rdEn,
  output logic              rdValid,
  output logic [REG_W-1:0]  rdData,
  output logic              irqEmpty,
  output logic              irqNotEmpty
);
  mboxStrobe_t        strobe;
  logic [NUM_DIR-1:0] dirFull, dirEmpty;
  logic [REG_W-1:0]   dpRdData;

  ipc_mbox_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .addr        (addr),
    .wrEn        (wrEn),
    .wrLow       (wrData[IRQ_N-1:0]),
    .rdEn        (rdEn),
    .dirFull     (dirFull),
    .dirEmpty    (dirEmpty),
    .dpRdData    (dpRdData),
    .strobe      (strobe),
    .rdValid     (rdValid),
    .rdData      (rdData),
    .irqEmpty    (irqEmpty),
    .irqNotEmpty (irqNotEmpty)
  );

  ipc_mbox_datapath #(.DEPTH(DEPTH)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrData   (wrData),
    .dirFull  (dirFull),
    .dirEmpty (dirEmpty),
    .dpRdData (dpRdData)
  );
endmodule

// File: tb/ipc_mbox_tb.sv
`timescale 1ns/1ps
module ipc_mbox_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  addr = '0;
  logic        wrEn = 1'b0;
  logic [63:0] wrData = '0;
  logic        rdEn = 1'b0;
  logic        rdValid;
  logic [63:0] rdData;
  logic        irqEmpty, irqNotEmpty;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [63:0] expQ[$];
  string       tagQ[$];

  logic [63:0] mW0 [2][16];
  logic [31:0] mW1 [2][16];
  int          mWp [2];
  int          mRp [2];
  int          mOcc[2];

  always #2.5 clk = ~clk;

  ipc_mbox u_dut (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .rdValid(rdValid), .rdData(rdData),
    .irqEmpty(irqEmpty), .irqNotEmpty(irqNotEmpty)
  );

  function automatic logic [7:0] statusA(input int d); return d ? 8'h80 : 8'h50; endfunction
  function automatic logic [7:0] sendA(input int d);   return d ? 8'h90 : 8'h60; endfunction
  function automatic logic [7:0] recvA(input int d);   return d ? 8'hA0 : 8'h70; endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && rdValid) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R11 unexpected rdValid", rdData, 64'h0);
      end else begin
        logic [63:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        chk(rdData === e, t, rdData, e);
      end
    end
  end

  task automatic busWr(input logic [7:0] a, input logic [63:0] d);
    @(negedge clk); addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic busRd(input logic [7:0] a, input logic [63:0] e, input string tag);
    @(negedge clk); addr = a; rdEn = 1'b1;
    expQ.push_back(e); tagQ.push_back(tag);
    @(negedge clk); rdEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input int d, input logic [63:0] w0, input logic [31:0] w1);
    busWr(sendA(d), w0);
    busWr(sendA(d) + 8'h08, {32'hFEED_F00D, w1});
    if (mOcc[d] < 16) begin
      mW0[d][mWp[d]] = w0;
      mW1[d][mWp[d]] = w1;
      mWp[d] = (mWp[d] + 1) % 16;
      mOcc[d]++;
    end
  endtask

  function automatic logic [63:0] statusExp(input int d);
    logic [63:0] v;
    int fr;
    v = '0;
    fr = 16 - mOcc[d];
    if (fr > 15) fr = 15;
    v[43:40] = 4'(mWp[d]);
    v[47:44] = 4'(mRp[d]);
    v[51:48] = 4'(fr);
    v[56:52] = 5'(mOcc[d]);
    if (mOcc[d] > 0) v[31:0] = mW1[d][mRp[d]];
    return v;
  endfunction

  task automatic recv1(input int d, input string tag);
    busRd(recvA(d) + 8'h08, statusExp(d), tag);
    if (mOcc[d] > 0) begin
      mRp[d] = (mRp[d] + 1) % 16;
      mOcc[d]--;
    end
  endtask

  task automatic recv0(input int d, input string tag);
    busRd(recvA(d), (mOcc[d] > 0) ? mW0[d][mRp[d]] : 64'h0, tag);
  endtask

  task automatic readStatus(input int d, input string tag);
    logic [63:0] e;
    e = '0;
    e[16] = (mOcc[d] == 16);
    e[17] = (mOcc[d] == 0);
    busRd(statusA(d), e, tag);
  endtask

  initial begin
    for (int d = 0; d < 2; d++) begin
      mWp[d] = 0; mRp[d] = 0; mOcc[d] = 0;
    end
    idle(4);
    rstN = 1'b1;
    idle(3);

    // R1 reset state
    chk(irqEmpty == 1'b0, "R1 irqEmpty after reset", 64'(irqEmpty), 64'h0);
    chk(irqNotEmpty == 1'b0, "R1 irqNotEmpty after reset", 64'(irqNotEmpty), 64'h0);
    busRd(8'h48, 64'h0, "R1 enable reg after reset");
    readStatus(0, "R1 A2I status after reset");
    readStatus(1, "R1 I2A status after reset");
    busRd(8'h4C, 64'h5, "R8 latched empties after reset");

    // R2 / R5 single message
    send(0, 64'h1122_3344_5566_7788, 32'hAABB_CCDD);
    readStatus(0, "R3 A2I status one entry");
    recv0(0, "R5 first word read");
    recv0(0, "R5 first word read again no pop");
    recv1(0, "R2 second word and pop");
    readStatus(0, "R5 status after pop");

    // R6 empty read
    recv1(0, "R6 empty second-word read");
    recv0(0, "R6 empty first-word read");

    // R3 / R4 / R7 fill, overflow, drain
    for (int i = 0; i < 16; i++)
      send(0, 64'hA000_0000_0000_0000 | 64'(i), 32'h5000_0000 | 32'(i * 3));
    readStatus(0, "R3 A2I full");
    send(0, 64'hDEAD_DEAD_DEAD_DEAD, 32'hBAD0_BAD0);
    readStatus(0, "R4 still full after dropped commit");
    for (int i = 0; i < 16; i++) begin
      recv0(0, "R4 drained head word0");
      recv1(0, "R7 drained status and payload");
    end
    readStatus(0, "R3 A2I empty after drain");

    // R12 independence
    send(1, 64'hCAFE_0000_0000_0001, 32'h0000_1001);
    send(1, 64'hCAFE_0000_0000_0002, 32'h0000_1002);
    readStatus(0, "R12 A2I unaffected by I2A traffic");
    readStatus(1, "R12 I2A holds two");
    recv0(1, "R12 I2A head word0");
    recv1(1, "R12 I2A pop 1");
    recv1(1, "R12 I2A pop 2");

    // R10 / R9 interrupts
    busWr(8'h48, 64'hF);
    busRd(8'h48, 64'hF, "R10 enable readback");
    chk(irqEmpty == 1'b1, "R10 irqEmpty with enabled empty events", 64'(irqEmpty), 64'h1);
    chk(irqNotEmpty == 1'b1, "R8 irqNotEmpty sticky from earlier traffic", 64'(irqNotEmpty), 64'h1);
    busWr(8'h4C, 64'hA);
    chk(irqNotEmpty == 1'b0, "R9 ack clears not-empty events", 64'(irqNotEmpty), 64'h0);
    busWr(8'h4C, 64'h5);
    chk(irqEmpty == 1'b1, "R9 ack while empty keeps event", 64'(irqEmpty), 64'h1);
    busRd(8'h4C, 64'h5, "R9 latched after acks");

    busWr(8'h48, 64'h2);
    chk(irqEmpty == 1'b0, "R10 empty masked", 64'(irqEmpty), 64'h0);
    send(0, 64'h0BAD_F00D_0000_0001, 32'h7777_0001);
    idle(2);
    chk(irqNotEmpty == 1'b1, "R8 not-empty event raises irq", 64'(irqNotEmpty), 64'h1);
    busWr(8'h4C, 64'h2);
    chk(irqNotEmpty == 1'b1, "R9 ack with message pending re-asserts", 64'(irqNotEmpty), 64'h1);
    recv1(0, "R2 pop pending message");
    idle(2);
    chk(irqNotEmpty == 1'b1, "R8 event sticky after FIFO emptied", 64'(irqNotEmpty), 64'h1);
    busWr(8'h4C, 64'h2);
    chk(irqNotEmpty == 1'b0, "R9 ack after condition passed clears", 64'(irqNotEmpty), 64'h0);
    busWr(8'h48, 64'h0);
    send(0, 64'h0000_0000_0000_00EE, 32'h0000_00EE);
    idle(2);
    chk(irqNotEmpty == 1'b0 && irqEmpty == 1'b0, "R10 all masked keeps irqs low",
        {62'h0, irqEmpty, irqNotEmpty}, 64'h0);
    busRd(8'h4C, 64'h7, "R8 latched with A2I not empty");
    recv1(0, "R2 pop last message");

    // R3 / R11 write ignored and unmapped read, latency
    busWr(8'h50, 64'hFFFF_FFFF_FFFF_FFFF);
    readStatus(0, "R3 status write ignored");
    @(negedge clk); addr = 8'h00; rdEn = 1'b1;
    expQ.push_back(64'h0); tagQ.push_back("R11 unmapped read zero");
    @(negedge clk); rdEn = 1'b0;
    chk(rdValid == 1'b1, "R11 rdValid one cycle after rdEn", 64'(rdValid), 64'h1);
    @(negedge clk);
    chk(rdValid == 1'b0, "R11 rdValid single pulse", 64'(rdValid), 64'h0);

    idle(4);
    chk(expQ.size() == 0, "R11 all reads returned", 64'(expQ.size()), 64'h0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%h expected=%h", 64'h0, 64'h1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule